// File: doc/BRIEF.md
# Reloadable DMA Transfer-Length Counter

This block holds the byte count for DMA transfers of a disk-bus host controller. The host writes a 24-bit length one byte at a time into a write-side shadow. The count the transfer engine sees, which is also the count the host reads back, is a separate copy. It changes only when a command is issued with its DMA flag set, and then it takes the shadow value. A count of zero stands for a 64 KiB transfer.

When the host starts a transfer-information step in DMA mode, the block works out the step length and loads it into a remaining-bytes register. The step length is the smaller of the effective count and the size of the phase, or of the count and 32 when command bytes are being collected. The transfer engine then reports how many bytes each beat moved. When the remainder reaches zero, the block gives a one-cycle done pulse. On the following edge it clears the readback count, sets the transfer-complete status and flags the cause as bus-service.

The controller is a three-state machine. `S_IDLE` waits for an accepted start. `S_XFER` counts beats down. `S_FINISH` lasts one cycle and performs the completion update. Its transitions are:
- `S_IDLE -> S_XFER` on an accepted start with a non-zero step length.
- `S_IDLE -> S_FINISH` on an accepted start with a step length of zero.
- `S_XFER -> S_FINISH` on the beat that empties the remainder.
- `S_FINISH -> S_IDLE` always.

Top module: `dma_len_counter`

## Requirements
- R1: The readback count is the concatenation of three byte registers selected by `wr_sel`: 0 for bits 7:0, 1 for bits 15:8 and 2 for bits 23:16.
- R2: Byte writes update only the shadow. The readback count does not change until a reload, a completion or a reset.
- R3: A write to any count byte clears `tc` on the next edge.
- R4: A command write with `cmd_dma`=1 copies the shadow into the readback count and sets `dma_mode`. With `cmd_dma`=0 it clears `dma_mode` and leaves the count alone. A start in non-DMA mode is ignored: `busy` stays low and `remain` is unchanged.
- R5: `eff_len` equals the readback count, except that a count of zero gives 65536.
- R6: An accepted start loads `remain` with min(`eff_len`, |`phase_len`|), with `phase_len` signed. With `cmd_mode`=1 it loads min(`eff_len`, 32) instead.
- R7: An accepted start clears `tc` and `bus_svc` on the same edge that loads `remain`.
- R8: Each `beat_valid` cycle in `S_XFER` lowers `remain` by `beat_bytes`, saturating at zero.
- R9: `done` is high for exactly one cycle, in `S_FINISH`, which follows the edge on which `remain` reached zero. On the next edge the readback count becomes 0, `tc` and `bus_svc` become 1, and `busy` falls.
- R10: When a count-byte write falls in the `done` cycle, the write wins: `tc` stays 0, while `bus_svc` is still set.
- R11: After reset the counts, `remain`, `tc`, `bus_svc`, `dma_mode`, `busy` and `done` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Host count-byte write strobe |
| wr_sel | input | 2 | Byte select: 0 low, 1 mid, 2 high |
| wr_data | input | 8 | Byte written |
| cmd_wr | input | 1 | Command write strobe |
| cmd_dma | input | 1 | DMA flag of the command |
| ti_start | input | 1 | Start a transfer-information step |
| cmd_mode | input | 1 | Command-collection mode, caps the step at 32 |
| phase_len | input | 25 | Signed remaining phase length |
| beat_valid | input | 1 | Transfer engine moved bytes this cycle |
| beat_bytes | input | 8 | Bytes moved in this beat |
| count_rb | output | 24 | Readback / engine count |
| eff_len | output | 25 | Effective length, with zero read as 65536 |
| remain | output | 25 | Bytes left in the current step |
| busy | output | 1 | Not in `S_IDLE` |
| done | output | 1 | One-cycle completion pulse |
| tc | output | 1 | Transfer-complete status |
| bus_svc | output | 1 | Cause flag: bus-service |
| dma_mode | output | 1 | Last command carried the DMA flag |

## Verification
Completion and a host count-byte write can fall on the same edge. Completion wants to set `tc`, and the write wants to clear it. The bench provokes this by driving a byte write in the very cycle in which `done` is observed high. It then expects `tc` low, `bus_svc` high and the readback count zeroed. A DMA reload arriving in that same `S_FINISH` cycle is the second such pairing; in that case the reload wins over the zeroing, and the checker covers it.

// File: rtl/dlc_pkg.sv
package dlc_pkg;
    typedef enum logic [1:0] {
        S_IDLE   = 2'd0,
        S_XFER   = 2'd1,
        S_FINISH = 2'd2
    } dlc_state_e;
endpackage

// File: rtl/dlc_regs.sv
module dlc_regs #(
    parameter int BYTE_W    = 8,
    parameter int NBYTES    = 3,
    parameter int EMPTY_LEN = 65536
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       wr_en,
    input  logic [$clog2(NBYTES)-1:0]  wr_sel,
    input  logic [BYTE_W-1:0]          wr_data,
    input  logic                       reload,
    input  logic                       clear,
    output logic [BYTE_W*NBYTES-1:0]   shadow,
    output logic [BYTE_W*NBYTES-1:0]   count_rb,
    output logic [BYTE_W*NBYTES:0]     eff_len
);
    localparam int CNT_W = BYTE_W * NBYTES;
    localparam int SEL_W = $clog2(NBYTES);

    for (genvar i = 0; i < NBYTES; i++) begin : g_byte
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                shadow[i*BYTE_W +: BYTE_W]   <= '0;
                count_rb[i*BYTE_W +: BYTE_W] <= '0;
            end else begin
                if (wr_en && wr_sel == SEL_W'(i))
                    shadow[i*BYTE_W +: BYTE_W] <= wr_data;
                // reload has priority over completion zeroing
                if (reload)
                    count_rb[i*BYTE_W +: BYTE_W] <= shadow[i*BYTE_W +: BYTE_W];
                else if (clear)
                    count_rb[i*BYTE_W +: BYTE_W] <= '0;
            end
        end
    end

    always_comb begin
        if (count_rb == '0) eff_len = (CNT_W+1)'(EMPTY_LEN);
        else                eff_len = {1'b0, count_rb};
    end
endmodule

// File: rtl/dlc_steplen.sv
module dlc_steplen #(
    parameter int LEN_W   = 25,
    parameter int CMD_MAX = 32
) (
    input  logic [LEN_W-1:0] eff_len,
    input  logic [LEN_W-1:0] phase_len,
    input  logic             cmd_mode,
    output logic [LEN_W-1:0] step_len
);
    logic [LEN_W-1:0] mag;
    logic [LEN_W-1:0] limit;

    always_comb begin
        mag      = phase_len[LEN_W-1] ? (~phase_len + 1'b1) : phase_len;
        limit    = cmd_mode ? LEN_W'(CMD_MAX) : mag;
        step_len = (eff_len < limit) ? eff_len : limit;
    end
endmodule

// File: rtl/dlc_fsm.sv
module dlc_fsm
    import dlc_pkg::*;
#(
    parameter int LEN_W  = 25,
    parameter int BEAT_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_req,
    input  logic [LEN_W-1:0]  step_len,
    input  logic              beat_valid,
    input  logic [BEAT_W-1:0] beat_bytes,
    output logic [LEN_W-1:0]  remain,
    output logic              busy,
    output logic              done
);
    dlc_state_e state, state_nx;
    logic [LEN_W-1:0] beat_ext;
    logic             beat_empties;

    assign beat_ext     = LEN_W'(beat_bytes);
    assign beat_empties = beat_valid && (beat_ext >= remain);

    always_ff @(posedge clk) begin
        if (!rst_n) state <= S_IDLE;
        else        state <= state_nx;
    end

    always_comb begin
        state_nx = state;
        unique case (state)
            S_IDLE:   if (start_req) state_nx = (step_len == '0) ? S_FINISH : S_XFER;
            S_XFER:   if (beat_empties) state_nx = S_FINISH;
            S_FINISH: state_nx = S_IDLE;
            default:  state_nx = S_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            remain <= '0;
        end else if (state == S_IDLE && start_req) begin
            remain <= step_len;
        end else if (state == S_XFER && beat_valid) begin
            remain <= beat_empties ? '0 : remain - beat_ext;
        end
    end

    always_comb begin
        busy = (state != S_IDLE);
        done = (state == S_FINISH);
    end
endmodule

// File: rtl/dma_len_counter.sv
module dma_len_counter #(
    parameter int BYTE_W    = 8,
    parameter int NBYTES    = 3,
    parameter int BEAT_W    = 8,
    parameter int CMD_MAX   = 32,
    parameter int EMPTY_LEN = 65536
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          wr_en,
    input  logic [$clog2(NBYTES)-1:0]     wr_sel,
    input  logic [BYTE_W-1:0]             wr_data,
    input  logic                          cmd_wr,
    input  logic                          cmd_dma,
    input  logic                          ti_start,
    input  logic                          cmd_mode,
    input  logic [BYTE_W*NBYTES:0]        phase_len,
    input  logic                          beat_valid,
    input  logic [BEAT_W-1:0]             beat_bytes,
    output logic [BYTE_W*NBYTES-1:0]      count_rb,
    output logic [BYTE_W*NBYTES:0]        eff_len,
    output logic [BYTE_W*NBYTES:0]        remain,
    output logic                          busy,
    output logic                          done,
    output logic                          tc,
    output logic                          bus_svc,
    output logic                          dma_mode
);
    localparam int CNT_W = BYTE_W * NBYTES;
    localparam int LEN_W = CNT_W + 1;

    logic [CNT_W-1:0] shadow;
    logic [LEN_W-1:0] step_len;
    logic             reload;
    logic             start_ok;

    assign reload   = cmd_wr && cmd_dma;
    assign start_ok = ti_start && dma_mode && !busy;

    dlc_regs #(.BYTE_W(BYTE_W), .NBYTES(NBYTES), .EMPTY_LEN(EMPTY_LEN)) u_regs (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
        .reload(reload), .clear(done), .shadow(shadow), .count_rb(count_rb),
        .eff_len(eff_len)
    );

    dlc_steplen #(.LEN_W(LEN_W), .CMD_MAX(CMD_MAX)) u_step (
        .eff_len(eff_len), .phase_len(phase_len), .cmd_mode(cmd_mode),
        .step_len(step_len)
    );

    dlc_fsm #(.LEN_W(LEN_W), .BEAT_W(BEAT_W)) u_fsm (
        .clk(clk), .rst_n(rst_n), .start_req(start_ok), .step_len(step_len),
        .beat_valid(beat_valid), .beat_bytes(beat_bytes), .remain(remain),
        .busy(busy), .done(done)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tc       <= 1'b0;
            bus_svc  <= 1'b0;
            dma_mode <= 1'b0;
        end else begin
            if (cmd_wr) dma_mode <= cmd_dma;
            // host count write wins over completion
            if (wr_en)         tc <= 1'b0;
            else if (done)     tc <= 1'b1;
            else if (start_ok) tc <= 1'b0;
            if (done)          bus_svc <= 1'b1;
            else if (start_ok) bus_svc <= 1'b0;
        end
    end
endmodule

// File: rtl/dlc_checker.sv
module dlc_checker #(
    parameter int CNT_W     = 24,
    parameter int EMPTY_LEN = 65536
) (
    input logic             clk,
    input logic             rst_n,
    input logic             wr_en,
    input logic             cmd_wr,
    input logic             cmd_dma,
    input logic             ti_start,
    input logic             dma_mode,
    input logic             busy,
    input logic             done,
    input logic             tc,
    input logic             bus_svc,
    input logic [CNT_W-1:0] shadow,
    input logic [CNT_W-1:0] count_rb,
    input logic [CNT_W:0]   eff_len,
    input logic [CNT_W:0]   remain
);
    p_write_clears_tc_r3: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> !tc);
    p_count_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!(cmd_wr && cmd_dma) && !done) |=> $stable(count_rb));
    p_reload_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_wr && cmd_dma) |=> count_rb == $past(shadow));
    p_nodma_ignore_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (ti_start && !dma_mode && !busy) |=> !busy);
    p_zero_len_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (count_rb == '0) |-> (eff_len == (CNT_W+1)'(EMPTY_LEN)));
    p_start_clears_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (ti_start && dma_mode && !busy) |=> (!tc && !bus_svc && busy));
    p_no_growth_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !done) |=> remain <= $past(remain));
    p_done_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
    p_finish_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !wr_en && !(cmd_wr && cmd_dma)) |=> (tc && bus_svc && count_rb == '0 && !busy));
    p_collide_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (done && wr_en) |=> (!tc && bus_svc));
endmodule

bind dma_len_counter dlc_checker u_chk (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .cmd_wr(cmd_wr), .cmd_dma(cmd_dma),
    .ti_start(ti_start), .dma_mode(dma_mode), .busy(busy), .done(done), .tc(tc),
    .bus_svc(bus_svc), .shadow(shadow), .count_rb(count_rb), .eff_len(eff_len),
    .remain(remain)
);

// File: tb/tb_dma_len_counter.sv
module tb_dma_len_counter;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [1:0]  wr_sel = '0;
    logic [7:0]  wr_data = '0;
    logic        cmd_wr = 1'b0, cmd_dma = 1'b0, ti_start = 1'b0, cmd_mode = 1'b0;
    logic [24:0] phase_len = '0;
    logic        beat_valid = 1'b0;
    logic [7:0]  beat_bytes = '0;
    logic [23:0] count_rb;
    logic [24:0] eff_len, remain;
    logic        busy, done, tc, bus_svc, dma_mode;

    int n_cmp = 0, n_bad = 0;
    logic [24:0] exp_q[$];
    logic        prev_busy = 1'b0;
    bit          finished = 1'b0;

    always #5 clk = ~clk;

    dma_len_counter dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
        .cmd_wr(cmd_wr), .cmd_dma(cmd_dma), .ti_start(ti_start), .cmd_mode(cmd_mode),
        .phase_len(phase_len), .beat_valid(beat_valid), .beat_bytes(beat_bytes),
        .count_rb(count_rb), .eff_len(eff_len), .remain(remain), .busy(busy),
        .done(done), .tc(tc), .bus_svc(bus_svc), .dma_mode(dma_mode)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // monitor: on each step start, compare loaded remainder with the scoreboard
    always @(negedge clk) begin
        if (rst_n && !finished) begin
            if (busy && !prev_busy) begin
                n_cmp++;
                if (exp_q.size() == 0) begin
                    n_bad++;
                    $display("FAIL R6 unexpected start actual=%0h expected=none", remain);
                end else begin
                    automatic logic [24:0] e = exp_q.pop_front();
                    if (remain !== e) begin
                        n_bad++;
                        $display("FAIL R6 step length actual=%0h expected=%0h", remain, e);
                    end
                end
            end
            prev_busy = busy;
        end
    end

    task automatic wr_byte(input logic [1:0] sel, input logic [7:0] d);
        @(negedge clk); wr_en = 1'b1; wr_sel = sel; wr_data = d;
        @(negedge clk); wr_en = 1'b0;
    endtask

    task automatic issue_cmd(input logic dma);
        @(negedge clk); cmd_wr = 1'b1; cmd_dma = dma;
        @(negedge clk); cmd_wr = 1'b0; cmd_dma = 1'b0;
    endtask

    task automatic start_step(input logic [24:0] ph, input logic cm, input bit expect_go,
                              input logic [24:0] exp_len);
        if (expect_go) exp_q.push_back(exp_len);
        @(negedge clk); ti_start = 1'b1; phase_len = ph; cmd_mode = cm;
        @(negedge clk); ti_start = 1'b0; cmd_mode = 1'b0;
    endtask

    task automatic beat(input logic [7:0] n);
        @(negedge clk); beat_valid = 1'b1; beat_bytes = n;
        @(negedge clk); beat_valid = 1'b0;
    endtask

    task automatic summary;
        finished = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_cmp++; n_bad++;
        $display("FAIL watchdog expired actual=hung expected=finished");
        summary();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R11 reset state
        check("R11 count_rb", count_rb, 0);
        check("R11 tc/bus_svc/dma/busy/done", {tc, bus_svc, dma_mode, busy, done}, 0);
        check("R11 remain", remain, 0);
        check("R5 zero count reads 65536", eff_len, 25'h10000);

        wr_byte(2'd0, 8'h34); wr_byte(2'd1, 8'h12); wr_byte(2'd2, 8'h00);
        check("R2 writes do not touch readback", count_rb, 0);
        issue_cmd(1'b1);
        check("R1 R4 reload", count_rb, 24'h001234);
        check("R4 dma_mode set", dma_mode, 1);
        check("R5 nonzero count", eff_len, 25'h001234);

        // phase +10 against count 0x1234
        start_step(25'd10, 1'b0, 1'b1, 25'd10);
        check("R7 start clears tc", tc, 0);
        beat(8'd4); check("R8 beat 1", remain, 6);
        beat(8'd4); check("R8 beat 2", remain, 2);
        check("R9 no early done", done, 0);
        beat(8'd4); check("R8 saturate at zero", remain, 0);
        check("R9 done pulse", done, 1);
        @(negedge clk);
        check("R9 done one cycle", done, 0);
        check("R9 finish tc/bus_svc/busy", {tc, bus_svc, busy}, 3'b110);
        check("R9 readback zeroed", count_rb, 0);

        wr_byte(2'd1, 8'h01);
        check("R3 byte write clears tc", tc, 0);
        check("R2 readback still zero", count_rb, 0);
        issue_cmd(1'b1);
        check("R1 reload 0x134", count_rb, 24'h000134);

        // negative phase, magnitude larger than count
        start_step(-25'sd1000, 1'b0, 1'b1, 25'd308);
        check("R7 start clears bus_svc", bus_svc, 0);
        beat(8'd200); check("R8 partial", remain, 108);
        beat(8'd200); check("R9 done after drain", done, 1);
        @(negedge clk);
        check("R9 tc set", tc, 1);

        wr_byte(2'd2, 8'hAB);
        issue_cmd(1'b1);
        check("R1 high byte position", count_rb, 24'hAB0134);
        check("R5 eff_len high", eff_len, 25'h0AB0134);

        wr_byte(2'd0, 8'h00); wr_byte(2'd1, 8'h00); wr_byte(2'd2, 8'h00);
        issue_cmd(1'b1);
        check("R5 zero reload gives 65536", eff_len, 25'h10000);
        start_step(25'd5, 1'b1, 1'b1, 25'd32);
        beat(8'd32);
        check("R10 done cycle", done, 1);
        // collision: byte write in the done cycle
        wr_en = 1'b1; wr_sel = 2'd0; wr_data = 8'h55;
        @(negedge clk); wr_en = 1'b0;
        check("R10 write beats completion on tc", tc, 0);
        check("R10 bus_svc still set", bus_svc, 1);
        check("R10 readback zeroed", count_rb, 0);

        issue_cmd(1'b0);
        check("R4 non-DMA command clears mode", dma_mode, 0);
        check("R4 non-DMA no reload", count_rb, 0);
        start_step(25'd7, 1'b0, 1'b0, 25'd0);
        check("R4 start ignored busy", busy, 0);
        check("R4 start ignored remain", remain, 0);

        issue_cmd(1'b1);
        check("R4 reload after re-enable", count_rb, 24'h000055);
        start_step(25'd0, 1'b0, 1'b1, 25'd0);
        check("R9 zero step goes straight to done", done, 1);
        @(negedge clk);
        check("R9 zero step completes", {tc, busy}, 2'b10);

        @(negedge clk);
        check("R6 scoreboard drained", exp_q.size(), 0);
        summary();
    end
endmodule